// File: doc/BRIEF.md
# Multi-Reference Clock Quality Monitor

This block watches several reference clocks at once. It samples each of them with the local system clock and reaches two verdicts per reference. The first is a period verdict: the spacing between successive rising edges, counted in system-clock cycles, must stay inside a programmable window. The second is a frequency verdict: the rising edges seen during a fixed gate time are counted, and that count is judged against two nested bands. A reference is declared failed when its count leaves the wide outer band. It is declared good again only when the count comes back inside the narrower inner band, so a count that sits near an edge of the band does not toggle the flag.

Both verdicts for every reference appear in a status vector. A qualified `good` vector feeds the logic that selects a reference. Software can mask any reference. A masked reference always reads as good on the qualified vector, while its raw status bits keep tracking its clock. The reference inputs must already be synchronised to the system clock. The block has no data stream, so every pin is a plain level signal.

Top module: `refclk_monitor`

## Requirements
- R1: While reset is held and directly after it, every status bit reads 1 (failed) and `good` equals `mask`.
- R2: When a rising edge of a reference is sampled and an earlier edge has been seen since reset, the count of system-clock cycles between the two edges is compared with the window [`per_min`, `per_max`]. A count outside the window sets that reference's period-fail bit and a count inside clears it. The new value is visible one clock after the edge is sampled.
- R3: If a reference shows no rising edge for more than `per_max` cycles, its period-fail bit is set without waiting for another edge.
- R4: Each gate lasts GATE_CYCLES system clocks. At the end of a gate, a reference whose frequency-fail bit is clear gets the bit set if its edge count for that gate is below `frq_out_lo` or above `frq_out_hi`. The bit does not change at any other time.
- R5: At the end of a gate, a reference whose frequency-fail bit is set gets the bit cleared only if the count lies within [`frq_in_lo`, `frq_in_hi`]. A count that is inside the outer band but outside the inner band leaves the bit unchanged in either state.
- R6: A reference held still for a whole gate ends up with both of its fail bits set. This holds when `frq_out_lo` is at least 1.
- R7: Status layout: bit 2i is the period-fail bit of reference i and bit 2i+1 is its frequency-fail bit.
- R8: When `mask[i]` is 1, `good[i]` reads 1 whatever the state of reference i. The status bits of that reference keep updating.
- R9: When `mask[i]` is 0, `good[i]` is 1 exactly when both fail bits of reference i are 0.
- R10: A fault on one reference leaves the status bits of the other references unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NREF | Synchronised reference clock levels |
| mask | input | NREF | 1 forces the qualified good bit of that reference |
| per_min | input | CW | Shortest accepted period, in clk cycles |
| per_max | input | CW | Longest accepted period, in clk cycles |
| frq_out_lo | input | FW | Lower edge of the fail band (edges per gate) |
| frq_out_hi | input | FW | Upper edge of the fail band |
| frq_in_lo | input | FW | Lower edge of the recover band |
| frq_in_hi | input | FW | Upper edge of the recover band |
| status | output | 2*NREF | Raw fail bits, layout as in R7 |
| good | output | NREF | Qualified per-reference good vector |

## Verification
The assertions assume three things. Each reference is already a clean synchronous level, so a rising edge is one sampled low-to-high step. The limits stay constant while the monitor runs. `per_max` stays below the saturation value of the period counter. The bench programs the limits once before reset and never changes them. It builds every reference from whole system-clock cycles, driven on the falling edge. The inner band it uses sits inside the outer band, and `frq_out_lo` is non-zero, so a stopped reference must fail both checks.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic {
    HYS_GOOD = 1'b0,
    HYS_FAIL = 1'b1
  } hys_state_t;
endpackage

// File: rtl/refmon_gate.sv
module refmon_gate #(
  parameter int GATE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end
);
  localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else if (tick == LAST) tick <= '0;
    else tick <= tick + 1'b1;
  end

  assign gate_end = (tick == LAST);

  // R4: a gate end is never followed directly by another one
  assert_gate_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> !gate_end);
  // R4: the gate timer never passes the gate length
  assert_gate_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= LAST);
endmodule

// File: rtl/refmon_period.sv
module refmon_period #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_i,
  input  logic [CW-1:0] per_min,
  input  logic [CW-1:0] per_max,
  output logic          edge_o,
  output logic          fail_o
);
  localparam logic [CW-1:0] SAT = '1;

  logic          ref_q;
  logic          seen;
  logic [CW-1:0] since;

  assign edge_o = ref_i & ~ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      seen   <= 1'b0;
      since  <= '0;
      fail_o <= 1'b1;
    end else begin
      ref_q <= ref_i;
      if (edge_o) begin
        seen  <= 1'b1;
        since <= CW'(1);
        if (seen) fail_o <= (since < per_min) || (since > per_max);
      end else begin
        if (since != SAT) since <= since + 1'b1;
        if (since > per_max) fail_o <= 1'b1;
      end
    end
  end

  // R2: the period flag clears only when an edge is judged
  assert_clear_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_o) |-> $past(edge_o));
  // R3: the period flag rises only on a judged edge or a timeout
  assert_fail_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> ($past(edge_o) || $past(since > per_max)));
endmodule

// File: rtl/refmon_freq.sv
module refmon_freq
  import refmon_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          gate_end,
  input  logic [FW-1:0] out_lo,
  input  logic [FW-1:0] out_hi,
  input  logic [FW-1:0] in_lo,
  input  logic [FW-1:0] in_hi,
  output logic          fail_o
);
  localparam logic [FW-1:0] SAT = '1;

  hys_state_t    st;
  logic [FW-1:0] edges;
  logic [FW:0]   total;
  logic          outside_outer;
  logic          inside_inner;

  assign total         = {1'b0, edges} + (FW+1)'(edge_i);
  assign outside_outer = (total < {1'b0, out_lo}) || (total > {1'b0, out_hi});
  assign inside_inner  = (total >= {1'b0, in_lo}) && (total <= {1'b0, in_hi});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= HYS_FAIL;
      edges <= '0;
    end else if (gate_end) begin
      edges <= '0;
      unique case (st)
        HYS_GOOD: if (outside_outer) st <= HYS_FAIL;
        HYS_FAIL: if (inside_inner)  st <= HYS_GOOD;
      endcase
    end else if (edge_i && edges != SAT) begin
      edges <= edges + 1'b1;
    end
  end

  assign fail_o = (st == HYS_FAIL);

  // R4: the frequency verdict moves only at a gate boundary
  assert_gate_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> $stable(fail_o));
  // R5: recovery needs an edge count that clears the lower edge of the inner band
  assert_recover_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_o) |-> ($past(edges) + FW'(1) >= $past(in_lo)));
endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor
  import refmon_pkg::*;
#(
  parameter int NREF        = 4,
  parameter int CW          = 16,
  parameter int FW          = 12,
  parameter int GATE_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREF-1:0]   ref_in,
  input  logic [NREF-1:0]   mask,
  input  logic [CW-1:0]     per_min,
  input  logic [CW-1:0]     per_max,
  input  logic [FW-1:0]     frq_out_lo,
  input  logic [FW-1:0]     frq_out_hi,
  input  logic [FW-1:0]     frq_in_lo,
  input  logic [FW-1:0]     frq_in_hi,
  output logic [2*NREF-1:0] status,
  output logic [NREF-1:0]   good
);
  logic            gate_end;
  logic [NREF-1:0] edge_w;
  logic [NREF-1:0] per_fail;
  logic [NREF-1:0] frq_fail;

  refmon_gate #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_end (gate_end)
  );

  for (genvar g = 0; g < NREF; g++) begin : g_ch
    refmon_period #(.CW(CW)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_i   (ref_in[g]),
      .per_min (per_min),
      .per_max (per_max),
      .edge_o  (edge_w[g]),
      .fail_o  (per_fail[g])
    );

    refmon_freq #(.FW(FW)) u_frq (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (edge_w[g]),
      .gate_end (gate_end),
      .out_lo   (frq_out_lo),
      .out_hi   (frq_out_hi),
      .in_lo    (frq_in_lo),
      .in_hi    (frq_in_hi),
      .fail_o   (frq_fail[g])
    );

    assign status[2*g]   = per_fail[g];
    assign status[2*g+1] = frq_fail[g];
    assign good[g]       = mask[g] | ~(per_fail[g] | frq_fail[g]);
  end
endmodule

// File: tb/tb_refclk_monitor.sv
module tb_refclk_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NREF = 4;
  localparam int GATE = 256;
  localparam int SETTLE = 4 * GATE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ref_in;
  logic [3:0]  mask = 4'h0;
  logic [15:0] per_min = 16'd8;
  logic [15:0] per_max = 16'd12;
  logic [11:0] frq_out_lo = 12'd22;
  logic [11:0] frq_out_hi = 12'd29;
  logic [11:0] frq_in_lo = 12'd24;
  logic [11:0] frq_in_hi = 12'd27;
  logic [7:0]  status;
  logic [3:0]  good;

  logic [3:0] gen_en = 4'hF;
  logic [3:0] gen_val = 4'h0;
  logic [3:0] man_val = 4'h0;
  int per_cfg [NREF];
  int gcnt [NREF];
  int total = 0;
  int bad = 0;

  assign ref_in = (gen_en & gen_val) | (~gen_en & man_val);

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_monitor dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mask(mask),
    .per_min(per_min), .per_max(per_max),
    .frq_out_lo(frq_out_lo), .frq_out_hi(frq_out_hi),
    .frq_in_lo(frq_in_lo), .frq_in_hi(frq_in_hi),
    .status(status), .good(good)
  );

  initial begin
    for (int i = 0; i < NREF; i++) begin
      per_cfg[i] = 10;
      gcnt[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NREF; i++) begin
        if (per_cfg[i] == 0) begin
          gen_val[i] = 1'b0;
          gcnt[i] = 0;
        end else begin
          if (gcnt[i] >= per_cfg[i] - 1) gcnt[i] = 0;
          else gcnt[i] = gcnt[i] + 1;
          gen_val[i] = (gcnt[i] < per_cfg[i] / 2);
        end
      end
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic t_reset();
    mask = 4'b0101;
    repeat (5) @(negedge clk);
    check("R1 status in reset", status, 8'hFF);
    check("R1 good in reset", good, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 8'hFF);
    check("R8 good after reset", good, 4'b0101);
    mask = 4'h0;
    @(negedge clk);
    check("R9 good unmasked after reset", good, 4'h0);
  endtask

  task automatic t_all_nominal();
    settle();
    check("R2 R5 nominal status", status, 8'h00);
    check("R9 nominal good", good, 4'hF);
  endtask

  task automatic t_slow_ref();
    per_cfg[1] = 13;
    settle();
    check("R7 R10 slow ref1 status", status, 8'h0C);
    check("R9 slow ref1 good", good, 4'b1101);
    mask = 4'b0010;
    @(negedge clk);
    check("R8 masked ref1 good", good, 4'hF);
    check("R8 masked ref1 status", status, 8'h0C);
    per_cfg[1] = 10;
    settle();
    check("R8 masked ref1 recovers", status, 8'h00);
    mask = 4'h0;
    @(negedge clk);
    check("R9 unmask good", good, 4'hF);
  endtask

  task automatic t_fast_ref();
    per_cfg[2] = 7;
    settle();
    check("R2 R4 fast ref2 status", status, 8'h30);
    per_cfg[2] = 10;
    settle();
    check("R5 fast ref2 recovered", status, 8'h00);
  endtask

  task automatic t_hysteresis();
    per_cfg[0] = 9;
    settle();
    check("R5 between bands stays good", status, 8'h00);
    per_cfg[0] = 7;
    settle();
    check("R4 ref0 leaves outer band", status, 8'h03);
    per_cfg[0] = 9;
    settle();
    check("R5 between bands stays failed", status, 8'h02);
    per_cfg[0] = 10;
    settle();
    check("R5 inner band recovers", status, 8'h00);
  endtask

  task automatic t_stopped();
    per_cfg[2] = 0;
    repeat (16) @(negedge clk);
    check("R3 timeout sets period fail", status[4], 1);
    settle();
    check("R6 stopped ref2 both fail", status, 8'h30);
    check("R9 stopped ref2 good", good, 4'b1011);
    per_cfg[2] = 10;
    settle();
    check("R6 ref2 restarted", status, 8'h00);
  endtask

  task automatic pulse(input int len);
    man_val[3] = 1'b1;
    repeat (len / 2) @(negedge clk);
    man_val[3] = 1'b0;
    repeat (len - len / 2) @(negedge clk);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    man_val[3] = 1'b0;
    gen_en[3] = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) pulse(10);
    check("R2 steady manual pulses", status[6], 0);
    pulse(5);
    man_val[3] = 1'b1;
    @(negedge clk);
    check("R2 short period flagged", status[6], 1);
    check("R10 glitch leaves others", status[5:0], 6'h00);
    repeat (4) @(negedge clk);
    man_val[3] = 1'b0;
    repeat (5) @(negedge clk);
    man_val[3] = 1'b1;
    @(negedge clk);
    check("R2 normal period clears", status[6], 0);
    check("R4 single glitch keeps freq good", status[7], 0);
    repeat (4) @(negedge clk);
    man_val[3] = 1'b0;
    gen_en[3] = 1'b1;
  endtask

  initial begin
    t_reset();
    t_all_nominal();
    t_slow_ref();
    t_fast_ref();
    t_hysteresis();
    t_stopped();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule